// File: doc/BRIEF.md
# Double-Precision Rounding and Post-Processing Unit

This block is the final stage of a floating-point arithmetic datapath. It receives an intermediate result that has more exponent range and three more bits of precision than an IEEE-754 binary64 value. It turns that intermediate into the packed 64-bit result, the exception flags, and a set of condition codes describing the result. The intermediate carries a sign, a signed unbiased exponent that is wider than the destination field, an integer bit, a 52-bit fraction, and three low-order bits: guard, round and sticky. Two class markers accompany it. They tell the block that the arithmetic stage already produced a NaN or an infinity.

The block works in a fixed order. It first tests whether the intermediate is too small to be a normalized binary64 number. If it is, the block flushes the result to a signed zero and skips rounding. Otherwise it rounds in the mode chosen on a 2-bit input. A carry out of the mantissa renormalizes the value. The block then tests the adjusted exponent for overflow and writes infinity or the largest finite value, depending on mode and sign. The condition codes are recomputed for every result and are registered together with it. Each accepted input gives exactly one output pulse after a fixed latency. Results are not generated as denormals.

Top module: `rnd_post_unit`

## Requirements
- R1: `out_valid` pulses exactly 1+`REG_MID` cycles after each cycle with `in_valid` high (2 with defaults) and is low otherwise. While `rst_n` is low, `out_valid`, `out_result`, the three flags and `out_cc` are all 0.
- R2: When `in_int`=1 and no class marker is set, an intermediate with `in_exp` < -1022 (two's complement, unbiased) underflows. The result is a zero with the input sign, `out_unfl`=1, `out_inex`=1 and `out_ovfl`=0. No rounding is applied, even when rounding would have reached the normal range.
- R3: Mode 00 is round-to-nearest-even. The magnitude is incremented when guard=1 and (round | sticky | fraction lsb) is set. An exact tie (guard,round,sticky = 1,0,0) with fraction lsb 0 is left unchanged.
- R4: Mode 01 is round-toward-zero. It never increments, even when guard, round and sticky are all 1.
- R5: Mode 10 (toward minus infinity) increments only negative values, and mode 11 (toward plus infinity) increments only positive values. In both cases at least one of guard, round or sticky must be 1.
- R6: When the increment carries out of an all-ones fraction, the result fraction becomes 0 and the exponent becomes `in_exp`+1.
- R7: Overflow is judged on the exponent after rounding and renormalization, and it occurs when that exponent exceeds 1023. On overflow, `out_ovfl`=1 and `out_inex`=1. The result is the largest finite value (exponent field 0x7FE, fraction all ones) for mode 01, for mode 10 with a positive sign, and for mode 11 with a negative sign. In every other case it is an infinity of the input sign.
- R8: For a normal, non-overflowing result, `out_inex` equals guard | round | sticky, and `out_unfl`=`out_ovfl`=0.
- R9: A normal result is packed with the sign at bit 63, the biased exponent (exponent + 1023) at bits 62:52 and the rounded fraction at bits 51:0.
- R10: `out_cc` is {N,Z,I,NAN} at bits 3..0. N equals result bit 63. Z marks a zero, I marks an infinity and NAN marks a NaN result. At most one of Z, I or NAN is set. The codes are rewritten with every result.
- R11: The class markers have a fixed priority: `in_nan` first, then `in_inf`, then `in_int`=0. `in_nan` yields 0x7FF8000000000000. `in_inf` yields a signed infinity. `in_int`=0 yields an exact signed zero. None of these raises a flag, and for all three the guard, round and sticky bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Intermediate result present this cycle |
| in_sign | input | 1 | Sign of the intermediate |
| in_exp | input | EXP_W (14) | Unbiased exponent, two's complement |
| in_int | input | 1 | Integer bit; 0 means a zero magnitude |
| in_frac | input | FRAC_W (52) | Fraction below the integer bit |
| in_grs | input | 3 | Guard, round, sticky (bit 2 = guard) |
| in_nan | input | 1 | Intermediate is a NaN |
| in_inf | input | 1 | Intermediate is an infinity |
| in_rmode | input | 2 | Rounding mode, encoded as in R3 to R5 |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 1+EXP_OUT_W+FRAC_W (64) | Packed binary64 result |
| out_unfl | output | 1 | Underflow flag |
| out_ovfl | output | 1 | Overflow flag |
| out_inex | output | 1 | Inexact flag |
| out_cc | output | 4 | Condition codes {N,Z,I,NAN} |

## Verification
The bench aims at the exact-tie vectors for round-to-nearest. A design that rounds ties away from zero fails on an even lsb, and one that ignores the lsb fails on an odd one. It also tries all three guard bits set under round-toward-zero, and both signs under each directed mode, where a design with the sign test inverted rounds the wrong half of the number line. It drives an all-ones fraction at exponent 1023. A design that checks overflow before rounding then misses the carry into overflow, and a design that does not renormalize produces a zero fraction with a stale exponent. Exponents just below the normal range, with round-up bits, catch a design that rounds before the underflow test. Random vectors across both range edges and all modes cover the rest.

// File: rtl/rnd_pkg.sv
package rnd_pkg;

   typedef enum logic [1:0] {
      RM_NEAREST = 2'b00,
      RM_ZERO    = 2'b01,
      RM_DOWN    = 2'b10,
      RM_UP      = 2'b11
   } rmode_e;

   typedef enum logic [2:0] {
      CLS_NORM = 3'd0,
      CLS_ZERO = 3'd1,
      CLS_UNFL = 3'd2,
      CLS_INF  = 3'd3,
      CLS_NAN  = 3'd4
   } cls_e;

   localparam int CC_N   = 3;
   localparam int CC_Z   = 2;
   localparam int CC_I   = 1;
   localparam int CC_NAN = 0;

   // Decide whether the magnitude grows by one lsb.
   function automatic logic round_up(input rmode_e mode, input logic sign,
                                     input logic lsb, input logic [2:0] grs);
      logic any;
      any = |grs;
      case (mode)
         RM_NEAREST: round_up = grs[2] & (grs[1] | grs[0] | lsb);
         RM_ZERO:    round_up = 1'b0;
         RM_DOWN:    round_up = sign & any;
         default:    round_up = ~sign & any;
      endcase
   endfunction

endpackage

// File: rtl/rnd_classify.sv
module rnd_classify import rnd_pkg::*; #(
   parameter int EXP_W     = 14,
   parameter int EXP_OUT_W = 11
) (
   input  logic             nan_i,
   input  logic             inf_i,
   input  logic             int_i,
   input  logic [EXP_W-1:0] exp_i,
   output cls_e             cls_o
);

   localparam int BIAS = (1 << (EXP_OUT_W - 1)) - 1;
   localparam int EMIN = 1 - BIAS;
   localparam logic signed [EXP_W-1:0] EMIN_S = EXP_W'(EMIN);

   logic too_small;

   // underflow is judged on the raw exponent, before any rounding
   assign too_small = $signed(exp_i) < EMIN_S;

   always_comb begin
      if (nan_i)          cls_o = CLS_NAN;
      else if (inf_i)     cls_o = CLS_INF;
      else if (!int_i)    cls_o = CLS_ZERO;
      else if (too_small) cls_o = CLS_UNFL;
      else                cls_o = CLS_NORM;
   end

endmodule

// File: rtl/rnd_increment.sv
module rnd_increment import rnd_pkg::*; #(
   parameter int FRAC_W          = 52,
   parameter bit CARRY_LOOKAHEAD = 1'b1
) (
   input  logic [1:0]        rmode_i,
   input  logic              sign_i,
   input  logic [FRAC_W-1:0] frac_i,
   input  logic [2:0]        grs_i,
   output logic [FRAC_W-1:0] frac_o,
   output logic              carry_o,
   output logic              inexact_o
);

   logic up;

   assign up        = round_up(rmode_e'(rmode_i), sign_i, frac_i[0], grs_i);
   assign inexact_o = |grs_i;

   generate
      if (CARRY_LOOKAHEAD) begin : g_cla
         // carry known from the all-ones test, in parallel with the adder
         assign frac_o  = frac_i + FRAC_W'(up);
         assign carry_o = up & (&frac_i);
      end else begin : g_ripple
         logic [FRAC_W:0] sum;
         assign sum     = {1'b0, frac_i} + {{FRAC_W{1'b0}}, up};
         assign frac_o  = sum[FRAC_W-1:0];
         assign carry_o = sum[FRAC_W];
      end
   endgenerate

endmodule

// File: rtl/rnd_pack.sv
module rnd_pack import rnd_pkg::*; #(
   parameter int EXP_W     = 14,
   parameter int EXP_OUT_W = 11,
   parameter int FRAC_W    = 52
) (
   input  cls_e                            cls_i,
   input  logic                            sign_i,
   input  logic [EXP_W-1:0]                exp_i,
   input  logic [FRAC_W-1:0]               frac_i,
   input  logic                            carry_i,
   input  logic                            inexact_i,
   input  logic [1:0]                      rmode_i,
   output logic [1+EXP_OUT_W+FRAC_W-1:0]   result_o,
   output logic                            unfl_o,
   output logic                            ovfl_o,
   output logic                            inex_o,
   output logic [3:0]                      cc_o
);

   localparam int RES_W = 1 + EXP_OUT_W + FRAC_W;
   localparam int BIAS  = (1 << (EXP_OUT_W - 1)) - 1;
   localparam int EMAX  = BIAS;
   localparam logic signed [EXP_W:0] EMAX_S = (EXP_W+1)'(EMAX);
   localparam logic [EXP_W:0]        BIAS_X = (EXP_W+1)'(BIAS);
   localparam logic [EXP_OUT_W-1:0]  E_ONES = '1;
   localparam logic [EXP_OUT_W-1:0]  E_MAXF = {{(EXP_OUT_W-1){1'b1}}, 1'b0};

   logic signed [EXP_W:0] exp_adj;
   logic                  ovf;
   logic                  to_max;
   logic [EXP_W:0]        bsum;
   rmode_e                mode;

   assign mode    = rmode_e'(rmode_i);
   // renormalization after a mantissa carry bumps the exponent
   assign exp_adj = $signed({exp_i[EXP_W-1], exp_i}) + $signed({{EXP_W{1'b0}}, carry_i});
   assign ovf     = exp_adj > EMAX_S;
   assign bsum    = exp_adj + BIAS_X;
   assign to_max  = (mode == RM_ZERO) || (mode == RM_DOWN && !sign_i) ||
                    (mode == RM_UP && sign_i);

   always_comb begin
      result_o = '0;
      unfl_o   = 1'b0;
      ovfl_o   = 1'b0;
      inex_o   = 1'b0;
      case (cls_i)
         CLS_NAN:  result_o = {1'b0, E_ONES, 1'b1, {(FRAC_W-1){1'b0}}};
         CLS_INF:  result_o = {sign_i, E_ONES, {FRAC_W{1'b0}}};
         CLS_ZERO: result_o = {sign_i, {(RES_W-1){1'b0}}};
         CLS_UNFL: begin
            result_o = {sign_i, {(RES_W-1){1'b0}}};
            unfl_o   = 1'b1;
            inex_o   = 1'b1;
         end
         default: begin
            if (ovf) begin
               ovfl_o = 1'b1;
               inex_o = 1'b1;
               if (to_max) result_o = {sign_i, E_MAXF, {FRAC_W{1'b1}}};
               else        result_o = {sign_i, E_ONES, {FRAC_W{1'b0}}};
            end else begin
               result_o = {sign_i, bsum[EXP_OUT_W-1:0], frac_i};
               inex_o   = inexact_i;
            end
         end
      endcase
   end

   // condition codes from the class decision, independent of the packed word
   always_comb begin
      cc_o         = '0;
      cc_o[CC_N]   = (cls_i == CLS_NAN) ? 1'b0 : sign_i;
      cc_o[CC_Z]   = (cls_i == CLS_ZERO) || (cls_i == CLS_UNFL);
      cc_o[CC_I]   = (cls_i == CLS_INF) || (cls_i == CLS_NORM && ovf && !to_max);
      cc_o[CC_NAN] = (cls_i == CLS_NAN);
   end

endmodule

// File: rtl/rnd_post_unit.sv
module rnd_post_unit import rnd_pkg::*; #(
   parameter int EXP_W           = 14,
   parameter int FRAC_W          = 52,
   parameter int EXP_OUT_W       = 11,
   parameter bit REG_MID         = 1'b1,
   parameter bit CARRY_LOOKAHEAD = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_valid,
   input  logic                          in_sign,
   input  logic [EXP_W-1:0]              in_exp,
   input  logic                          in_int,
   input  logic [FRAC_W-1:0]             in_frac,
   input  logic [2:0]                    in_grs,
   input  logic                          in_nan,
   input  logic                          in_inf,
   input  logic [1:0]                    in_rmode,
   output logic                          out_valid,
   output logic [1+EXP_OUT_W+FRAC_W-1:0] out_result,
   output logic                          out_unfl,
   output logic                          out_ovfl,
   output logic                          out_inex,
   output logic [3:0]                    out_cc
);

   localparam int RES_W = 1 + EXP_OUT_W + FRAC_W;

   // elaboration-time parameter checks
   generate
      if (EXP_W < EXP_OUT_W + 2) begin : g_bad_exp
         $error("rnd_post_unit: EXP_W must exceed EXP_OUT_W by at least 2");
      end
      if (FRAC_W < 2) begin : g_bad_frac
         $error("rnd_post_unit: FRAC_W must be at least 2");
      end
      if (EXP_OUT_W < 3) begin : g_bad_eout
         $error("rnd_post_unit: EXP_OUT_W must be at least 3");
      end
   endgenerate

   // ---------------- front: classify and round ----------------
   cls_e              a_cls;
   logic [FRAC_W-1:0] a_frac;
   logic              a_carry;
   logic              a_inexact;

   rnd_classify #(.EXP_W(EXP_W), .EXP_OUT_W(EXP_OUT_W)) u_cls (
      .nan_i (in_nan),
      .inf_i (in_inf),
      .int_i (in_int),
      .exp_i (in_exp),
      .cls_o (a_cls)
   );

   rnd_increment #(.FRAC_W(FRAC_W), .CARRY_LOOKAHEAD(CARRY_LOOKAHEAD)) u_inc (
      .rmode_i   (in_rmode),
      .sign_i    (in_sign),
      .frac_i    (in_frac),
      .grs_i     (in_grs),
      .frac_o    (a_frac),
      .carry_o   (a_carry),
      .inexact_o (a_inexact)
   );

   // ---------------- optional middle register ----------------
   logic              b_valid;
   cls_e              b_cls;
   logic              b_sign;
   logic [EXP_W-1:0]  b_exp;
   logic [FRAC_W-1:0] b_frac;
   logic              b_carry;
   logic              b_inexact;
   logic [1:0]        b_rmode;

   generate
      if (REG_MID) begin : g_mid
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               b_valid   <= 1'b0;
               b_cls     <= CLS_ZERO;
               b_sign    <= 1'b0;
               b_exp     <= '0;
               b_frac    <= '0;
               b_carry   <= 1'b0;
               b_inexact <= 1'b0;
               b_rmode   <= '0;
            end else begin
               b_valid <= in_valid;
               if (in_valid) begin
                  b_cls     <= a_cls;
                  b_sign    <= in_sign;
                  b_exp     <= in_exp;
                  b_frac    <= a_frac;
                  b_carry   <= a_carry;
                  b_inexact <= a_inexact;
                  b_rmode   <= in_rmode;
               end
            end
         end
      end else begin : g_flow
         assign b_valid   = in_valid;
         assign b_cls     = a_cls;
         assign b_sign    = in_sign;
         assign b_exp     = in_exp;
         assign b_frac    = a_frac;
         assign b_carry   = a_carry;
         assign b_inexact = a_inexact;
         assign b_rmode   = in_rmode;
      end
   endgenerate

   // ---------------- back: overflow check and packing ----------------
   logic [RES_W-1:0] p_result;
   logic             p_unfl;
   logic             p_ovfl;
   logic             p_inex;
   logic [3:0]       p_cc;

   rnd_pack #(.EXP_W(EXP_W), .EXP_OUT_W(EXP_OUT_W), .FRAC_W(FRAC_W)) u_pack (
      .cls_i     (b_cls),
      .sign_i    (b_sign),
      .exp_i     (b_exp),
      .frac_i    (b_frac),
      .carry_i   (b_carry),
      .inexact_i (b_inexact),
      .rmode_i   (b_rmode),
      .result_o  (p_result),
      .unfl_o    (p_unfl),
      .ovfl_o    (p_ovfl),
      .inex_o    (p_inex),
      .cc_o      (p_cc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_result <= '0;
         out_unfl   <= 1'b0;
         out_ovfl   <= 1'b0;
         out_inex   <= 1'b0;
         out_cc     <= '0;
      end else begin
         out_valid <= b_valid;
         if (b_valid) begin
            out_result <= p_result;
            out_unfl   <= p_unfl;
            out_ovfl   <= p_ovfl;
            out_inex   <= p_inex;
            out_cc     <= p_cc;
         end
      end
   end

endmodule

// File: rtl/rnd_post_chk.sv
module rnd_post_chk #(
   parameter int FRAC_W    = 52,
   parameter int EXP_OUT_W = 11,
   parameter bit REG_MID   = 1'b1
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          in_valid,
   input logic                          out_valid,
   input logic [1+EXP_OUT_W+FRAC_W-1:0] out_result,
   input logic                          out_unfl,
   input logic                          out_ovfl,
   input logic                          out_inex,
   input logic [3:0]                    out_cc
);

   localparam int RES_W = 1 + EXP_OUT_W + FRAC_W;

   logic [1:0] seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             seen <= '0;
      else if (seen != 2'd3)  seen <= seen + 2'd1;
   end

   generate
      if (REG_MID) begin : g_lat2
         a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
            (seen >= 2'd2) |-> (out_valid == $past(in_valid, 2)));
      end else begin : g_lat1
         a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
            (seen >= 2'd1) |-> (out_valid == $past(in_valid, 1)));
      end
   endgenerate

   a_r2_unfl_gives_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_unfl) |-> (out_result[RES_W-2:0] == '0 && out_inex && !out_ovfl));

   a_r7_ovfl_is_inexact: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ovfl) |-> (out_inex && !out_unfl &&
         (out_result[FRAC_W +: EXP_OUT_W] == {EXP_OUT_W{1'b1}} ||
          out_result[FRAC_W +: EXP_OUT_W] == {{(EXP_OUT_W-1){1'b1}}, 1'b0})));

   a_r10_sign_code: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_cc[3] == out_result[RES_W-1]));

   a_r10_class_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $onehot0(out_cc[2:0]));

   a_r10_inf_encoding: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_cc[1]) |->
         (out_result[RES_W-2:0] == {{EXP_OUT_W{1'b1}}, {FRAC_W{1'b0}}}));

   a_r11_nan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_cc[0]) |-> (!out_unfl && !out_ovfl && !out_inex &&
         out_result[FRAC_W +: EXP_OUT_W] == {EXP_OUT_W{1'b1}}));

endmodule

bind rnd_post_unit rnd_post_chk #(
   .FRAC_W    (FRAC_W),
   .EXP_OUT_W (EXP_OUT_W),
   .REG_MID   (REG_MID)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .out_valid  (out_valid),
   .out_result (out_result),
   .out_unfl   (out_unfl),
   .out_ovfl   (out_ovfl),
   .out_inex   (out_inex),
   .out_cc     (out_cc)
);

// File: tb/sim_rnd_post_unit.sv
module sim_rnd_post_unit;

   localparam int  CLK_PERIOD = 10;
   localparam bit  REG_MID    = 1'b1;
   localparam int  LAT        = 1 + REG_MID;
   localparam int  N_RANDOM   = 4000;
   localparam logic [51:0] F_ONES = '1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_sign = 1'b0;
   logic [13:0] in_exp = '0;
   logic        in_int = 1'b0;
   logic [51:0] in_frac = '0;
   logic [2:0]  in_grs = '0;
   logic        in_nan = 1'b0;
   logic        in_inf = 1'b0;
   logic [1:0]  in_rmode = '0;
   logic        out_valid;
   logic [63:0] out_result;
   logic        out_unfl;
   logic        out_ovfl;
   logic        out_inex;
   logic [3:0]  out_cc;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;

   // expectation pipeline, index LAT-1 is due at the outputs
   bit          pv   [2];
   logic [63:0] pres [2];
   bit          pu   [2];
   bit          po   [2];
   bit          px   [2];
   logic [3:0]  pcc  [2];
   string       ptag [2];

   bit          cv;
   logic [63:0] cres;
   bit          cu, co, cx;
   logic [3:0]  ccc;
   string       ctag;

   always #(CLK_PERIOD/2) clk = ~clk;

   rnd_post_unit #(.REG_MID(REG_MID)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
      .in_exp(in_exp), .in_int(in_int), .in_frac(in_frac), .in_grs(in_grs),
      .in_nan(in_nan), .in_inf(in_inf), .in_rmode(in_rmode),
      .out_valid(out_valid), .out_result(out_result), .out_unfl(out_unfl),
      .out_ovfl(out_ovfl), .out_inex(out_inex), .out_cc(out_cc)
   );

   // behavioural reference for one intermediate
   task automatic model(input bit s, input int e, input bit ib, input logic [51:0] f,
                        input logic [2:0] g, input logic [1:0] md, input bit nan, input bit inf,
                        output logic [63:0] r, output bit u, output bit o, output bit x,
                        output logic [3:0] c, output string t);
      longint m;
      int     rem;
      bit     up;
      u = 0; o = 0; x = 0;
      if (nan) begin
         r = 64'h7FF8_0000_0000_0000; t = "R11";
      end else if (inf) begin
         r = {s, 11'h7FF, 52'd0}; t = "R11";
      end else if (!ib) begin
         r = {s, 63'd0}; t = "R11";
      end else if (e < -1022) begin
         r = {s, 63'd0}; u = 1; x = 1; t = "R2";
      end else begin
         m   = longint'({1'b1, f});
         rem = int'(g);
         up  = 0;
         if (md == 2'b00) begin
            if (rem > 4) up = 1;
            else if (rem == 4) up = f[0];
            t = "R3";
         end else if (md == 2'b01) begin
            t = "R4";
         end else if (md == 2'b10) begin
            up = s && rem != 0; t = "R5";
         end else begin
            up = !s && rem != 0; t = "R5";
         end
         if (up) m = m + 1;
         if (m >= (longint'(1) <<< 53)) begin
            m = m >>> 1; e = e + 1; t = "R6";
         end
         if (e > 1023) begin
            o = 1; x = 1; t = "R7";
            if (md == 2'b01 || (md == 2'b10 && !s) || (md == 2'b11 && s))
               r = {s, 11'h7FE, F_ONES};
            else
               r = {s, 11'h7FF, 52'd0};
         end else begin
            r = {s, 11'(e + 1023), m[51:0]};
            x = (rem != 0);
            if (rem == 0 && t != "R6") t = "R9";
         end
      end
      c[3] = r[63];
      c[2] = (r[62:0] == 63'd0);
      c[1] = (r[62:52] == 11'h7FF) && (r[51:0] == 52'd0);
      c[0] = (r[62:52] == 11'h7FF) && (r[51:0] != 52'd0);
   endtask

   task automatic check_outputs();
      checks++;
      if (out_valid !== pv[LAT-1]) begin
         errors++;
         $display("FAIL R1: out_valid actual=%b expected=%b", out_valid, pv[LAT-1]);
      end
      if (pv[LAT-1]) begin
         checks++;
         if (out_result !== pres[LAT-1]) begin
            errors++;
            $display("FAIL %s: result actual=%h expected=%h", ptag[LAT-1], out_result, pres[LAT-1]);
         end
         checks++;
         if ({out_unfl, out_ovfl} !== {pu[LAT-1], po[LAT-1]}) begin
            errors++;
            $display("FAIL %s: unfl/ovfl actual=%b%b expected=%b%b", ptag[LAT-1],
                     out_unfl, out_ovfl, pu[LAT-1], po[LAT-1]);
         end
         checks++;
         if (out_inex !== px[LAT-1]) begin
            errors++;
            $display("FAIL R8 (%s): inex actual=%b expected=%b", ptag[LAT-1], out_inex, px[LAT-1]);
         end
         checks++;
         if (out_cc !== pcc[LAT-1]) begin
            errors++;
            $display("FAIL R10 (%s): cc actual=%b expected=%b", ptag[LAT-1], out_cc, pcc[LAT-1]);
         end
      end
   endtask

   // one clock: advance expectations, compare, leave inputs to the caller
   task automatic tick();
      @(negedge clk);
      for (int i = 1; i >= 1; i--) begin
         pv[i] = pv[i-1]; pres[i] = pres[i-1]; pu[i] = pu[i-1];
         po[i] = po[i-1]; px[i] = px[i-1]; pcc[i] = pcc[i-1]; ptag[i] = ptag[i-1];
      end
      pv[0] = cv; pres[0] = cres; pu[0] = cu; po[0] = co; px[0] = cx; pcc[0] = ccc; ptag[0] = ctag;
      check_outputs();
   endtask

   task automatic issue(input bit s, input int e, input bit ib, input logic [51:0] f,
                        input logic [2:0] g, input logic [1:0] md, input bit nan, input bit inf);
      tick();
      in_valid = 1; in_sign = s; in_exp = 14'(e); in_int = ib; in_frac = f;
      in_grs = g; in_rmode = md; in_nan = nan; in_inf = inf;
      cv = 1;
      model(s, e, ib, f, g, md, nan, inf, cres, cu, co, cx, ccc, ctag);
   endtask

   task automatic idle();
      tick();
      in_valid = 0;
      in_grs   = 3'($urandom);
      cv       = 0;
   endtask

   initial begin
      for (int i = 0; i < 2; i++) pv[i] = 0;
      cv = 0;
      repeat (3) @(negedge clk);
      // R1: reset state
      checks++;
      if (out_valid !== 0 || out_result !== 0 || out_unfl !== 0 || out_ovfl !== 0 ||
          out_inex !== 0 || out_cc !== 0) begin
         errors++;
         $display("FAIL R1: reset outputs actual=%b %h %b%b%b %b expected=0", out_valid,
                  out_result, out_unfl, out_ovfl, out_inex, out_cc);
      end
      rst_n = 1;

      // R3: nearest-even ties and neighbours
      issue(0, 3, 1, 52'h0_0000_0000_0004, 3'b100, 2'b00, 0, 0);
      issue(0, 3, 1, 52'h0_0000_0000_0005, 3'b100, 2'b00, 0, 0);
      issue(1, 3, 1, 52'h0_0000_0000_0004, 3'b101, 2'b00, 0, 0);
      issue(0, 3, 1, 52'h0_0000_0000_0005, 3'b011, 2'b00, 0, 0);
      // R4: toward zero discards everything
      issue(0, 7, 1, 52'h1_2345_6789_ABCD, 3'b111, 2'b01, 0, 0);
      issue(1, 7, 1, 52'h1_2345_6789_ABCD, 3'b111, 2'b01, 0, 0);
      // R5: directed modes by sign
      issue(1, -5, 1, 52'h0_0000_0000_0010, 3'b001, 2'b10, 0, 0);
      issue(0, -5, 1, 52'h0_0000_0000_0010, 3'b001, 2'b10, 0, 0);
      issue(0, -5, 1, 52'h0_0000_0000_0010, 3'b001, 2'b11, 0, 0);
      issue(1, -5, 1, 52'h0_0000_0000_0010, 3'b001, 2'b11, 0, 0);
      // R6: carry renormalization
      issue(0, 5, 1, F_ONES, 3'b110, 2'b00, 0, 0);
      // R7: rounding carries into overflow; boundary without carry
      issue(0, 1023, 1, F_ONES, 3'b100, 2'b00, 0, 0);
      issue(0, 1023, 1, F_ONES, 3'b111, 2'b01, 0, 0);
      for (int md = 0; md < 4; md++) begin
         issue(0, 1024, 1, 52'h8_0000_0000_0000, 3'b000, 2'(md), 0, 0);
         issue(1, 1024, 1, 52'h8_0000_0000_0000, 3'b000, 2'(md), 0, 0);
      end
      // R2: underflow ahead of rounding; lowest normal exponent
      issue(0, -1023, 1, F_ONES, 3'b111, 2'b11, 0, 0);
      issue(1, -2000, 1, 52'h0, 3'b000, 2'b00, 0, 0);
      issue(1, -1022, 1, 52'h0, 3'b000, 2'b00, 0, 0);
      // R9: exact normal
      issue(0, 0, 1, 52'hA_5A5A_5A5A_5A5A, 3'b000, 2'b00, 0, 0);
      // R11: markers and zero with guard bits set
      issue(0, 9999, 1, 52'h1, 3'b111, 2'b11, 1, 1);
      issue(1, 0, 1, 52'h1, 3'b111, 2'b00, 0, 1);
      issue(1, -3000, 0, 52'h0, 3'b111, 2'b11, 0, 0);
      idle();
      idle();

      // random sweep across both range edges, all modes, with gaps
      for (int n = 0; n < N_RANDOM; n++) begin
         if ($urandom_range(0, 9) == 0) begin
            idle();
         end else begin
            logic [51:0] f;
            int          e;
            int          pick;
            f    = {20'($urandom), $urandom};
            if ($urandom_range(0, 7) == 0) f = F_ONES;
            pick = $urandom_range(0, 3);
            if (pick == 0)      e = $urandom_range(0, 20) - 1033;
            else if (pick == 1) e = $urandom_range(0, 20) + 1013;
            else                e = $urandom_range(0, 2200) - 1100;
            issue(1'($urandom), e, $urandom_range(0, 30) != 0, f, 3'($urandom), 2'($urandom),
                  $urandom_range(0, 40) == 0, $urandom_range(0, 40) == 0);
         end
      end
      for (int i = 0; i < LAT + 2; i++) idle();

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL R1: watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule